// File: doc/BRIEF.md
# Edge and Pulse Event Counter

This block tallies events seen on a single asynchronous digital input and keeps a 16-bit running total that a register reader can sample at any moment. A typical use is counting interrupt requests raised by a peripheral, where the host later reads how many have occurred since the last clear.

The input first passes through a two-stage synchronizer, and then an edge detector. A small state machine qualifies the edges according to a 2-bit mode. In the edge modes every qualifying edge is an event. In the pulse modes an event is counted only when a complete pulse ends: a leading edge must first be seen, and the matching trailing edge then produces the event. The state machine has three states. `QS_EDGE` is used for the edge modes. `QS_SEEK` waits for a leading edge in a pulse mode. `QS_HELD` is inside a pulse and waits for its trailing edge. Its transitions are these:
- `T_ENTER_EDGE`: a mode change to an edge mode moves to `QS_EDGE`.
- `T_ENTER_PULSE`: a mode change to a pulse mode moves to `QS_SEEK`.
- `T_LEAD`: `QS_SEEK` moves to `QS_HELD` on the leading edge.
- `T_TRAIL`: `QS_HELD` moves back to `QS_SEEK` on the trailing edge and emits an event.

A mode change always restarts qualification. A read strobe copies the live count into the output register. A clear strobe zeroes the live count.

Top module: `evt_pulse_counter`

## Requirements
- R1: After reset the live count and the read output are both zero, and the mode register holds rising-edge mode (code 00).
- R2: In mode 00 each low-to-high transition of the input adds one to the count, and high-to-low transitions add nothing.
- R3: In mode 01 each high-to-low transition adds one, and low-to-high transitions add nothing.
- R4: In mode 10 a positive pulse adds one when its closing high-to-low transition arrives. The opening low-to-high transition alone adds nothing.
- R5: In mode 11 a negative pulse adds one when its closing low-to-high transition arrives. The opening high-to-low transition alone adds nothing.
- R6: The count changes by at most one per clock, and only on a qualified event or a clear.
- R7: The count wraps from 0xFFFF to 0x0000 on the next event.
- R8: A clear strobe sets the count to zero. A clear in the same cycle as an event also leaves zero.
- R9: A mode change discards a pulse already in progress and any event in the cycle of the change. The first pulse counted in a pulse mode must begin after the change.
- R10: A read strobe loads the live count into `count_o` one clock later. Without a read strobe, `count_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_async | input | 1 | External input to be counted, not synchronized |
| mode | input | 2 | 00 rising edge, 01 falling edge, 10 positive pulse, 11 negative pulse |
| clr | input | 1 | Clear strobe for the live count |
| rd | input | 1 | Read strobe; loads the live count into `count_o` |
| count_o | output | 16 | Count value captured at the last read strobe |

## Verification
In each mode the input is driven through single transitions in both directions, with a read between them. This separates edge counting from pulse counting, and separates the two polarities: a wrong mode decode counts on the wrong transition.

Several further patterns are applied:
- A pulse opened before a mode change and closed after it checks that partial pulses are discarded.
- A clear timed onto the very cycle of an event checks that the clear wins.
- A burst of edges with no read strobe checks that `count_o` holds.
- An input toggled on every clock through 65536 rising edges checks back-to-back counting and the wrap from 0xFFFF to zero.

// File: rtl/evc_pkg.sv
package evc_pkg;
    typedef enum logic [1:0] {
        EVM_RISE   = 2'b00,
        EVM_FALL   = 2'b01,
        EVM_PPULSE = 2'b10,
        EVM_NPULSE = 2'b11
    } evc_mode_e;

    typedef enum logic [1:0] {
        QS_EDGE = 2'b00,
        QS_SEEK = 2'b01,
        QS_HELD = 2'b10
    } evc_state_e;
endpackage

// File: rtl/evc_sync.sv
// Multi-stage synchronizer followed by a one-cycle edge detector.
module evc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh;

    generate
        for (genvar i = 0; i <= LAST; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh[0] <= 1'b0;
                    else        sh[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh[i] <= 1'b0;
                    else        sh[i] <= sh[i-1];
                end
            end
        end
    endgenerate

    // sh[LAST-1] is the synchronized level; sh[LAST] is its previous value.
    assign rise = sh[LAST-1] & ~sh[LAST];
    assign fall = ~sh[LAST-1] & sh[LAST];
endmodule

// File: rtl/evc_qual.sv
// Event qualifier: turns edges into counted events according to the mode.
module evc_qual
    import evc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       rise,
    input  logic       fall,
    output logic [1:0] mode_q,
    output logic       hit
);
    evc_state_e st, st_nxt;
    evc_mode_e  cur_mode;
    logic       chg;
    logic       lead, trail, edge_hit;

    assign cur_mode = evc_mode_e'(mode_q);
    assign chg      = (mode != mode_q);

    always_comb begin
        lead     = 1'b0;
        trail    = 1'b0;
        edge_hit = 1'b0;
        unique case (cur_mode)
            EVM_RISE:   edge_hit = rise;
            EVM_FALL:   edge_hit = fall;
            EVM_PPULSE: begin lead = rise; trail = fall; end
            EVM_NPULSE: begin lead = fall; trail = rise; end
        endcase
    end

    // State register (mode register alongside it)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= QS_EDGE;
            mode_q <= EVM_RISE;
        end else begin
            st     <= st_nxt;
            mode_q <= mode;
        end
    end

    // Next state
    always_comb begin
        st_nxt = st;
        if (chg) begin
            st_nxt = mode[1] ? QS_SEEK : QS_EDGE;     // T_ENTER_PULSE / T_ENTER_EDGE
        end else begin
            unique case (st)
                QS_EDGE: st_nxt = QS_EDGE;
                QS_SEEK: if (lead)  st_nxt = QS_HELD; // T_LEAD
                QS_HELD: if (trail) st_nxt = QS_SEEK; // T_TRAIL
                default: st_nxt = QS_EDGE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        hit = 1'b0;
        if (!chg) begin
            unique case (st)
                QS_EDGE: hit = edge_hit;
                QS_SEEK: hit = 1'b0;
                QS_HELD: hit = trail;
                default: hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/evc_accum.sv
// Wrapping event count plus read snapshot register.
module evc_accum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         hit,
    input  logic         rd,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] rd_q
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (hit) cnt_q <= cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rd_q <= '0;
        else if (rd) rd_q <= cnt_q;
    end
endmodule

// File: rtl/evt_pulse_counter.sv
module evt_pulse_counter #(
    parameter int CNT_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_async,
    input  logic [1:0]       mode,
    input  logic             clr,
    input  logic             rd,
    output logic [CNT_W-1:0] count_o
);
    logic             s_rise, s_fall;
    logic             qual_hit;
    logic [1:0]       qual_mode_q;
    logic [CNT_W-1:0] live_cnt;

    evc_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin_async),
        .rise (s_rise),
        .fall (s_fall)
    );

    evc_qual u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .rise  (s_rise),
        .fall  (s_fall),
        .mode_q(qual_mode_q),
        .hit   (qual_hit)
    );

    evc_accum #(.W(CNT_W)) u_accum (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .hit  (qual_hit),
        .rd   (rd),
        .cnt_q(live_cnt),
        .rd_q (count_o)
    );
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         rd,
    input logic [1:0]   mode,
    input logic [1:0]   mode_q,
    input logic         hit,
    input logic [W-1:0] cnt,
    input logic [W-1:0] rd_val
);
    localparam logic [W-1:0] ONE = W'(1);

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + ONE)));

    p_no_event_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hit) |=> $stable(cnt));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && hit && (cnt == '1)) |=> (cnt == '0));

    p_mode_change_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (mode != mode_q)) |=> $stable(cnt));

    p_read_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (rd_val == $past(cnt)));

    p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rd_val));
endmodule

bind evt_pulse_counter evc_checker #(.W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .rd    (rd),
    .mode  (mode),
    .mode_q(qual_mode_q),
    .hit   (qual_hit),
    .cnt   (live_cnt),
    .rd_val(count_o)
);

// File: tb/evt_pulse_counter_tb.sv
module evt_pulse_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_async = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        clr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] count_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_pulse_counter u_dut (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
        .mode(mode), .clr(clr), .rd(rd), .count_o(count_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic read_count(output logic [15:0] v);
        rd = 1'b1;
        tick(1);
        rd = 1'b0;
        v = count_o;
    endtask

    task automatic set_pin(input logic v);
        pin_async = v;
        tick(4);
    endtask

    task automatic do_clear();
        tick(4);
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode = m;
        tick(2);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 reset output", count_o, 16'h0000);
        set_pin(1'b1);
        read_count(v);
        check("R1 default rising mode counts", v, 16'h0001);
        set_pin(1'b0);
        do_clear();
    endtask

    task automatic t_rise();
        logic [15:0] v;
        set_mode(2'b00);
        do_clear();
        set_pin(1'b1); read_count(v); check("R2 first rise", v, 16'h0001);
        set_pin(1'b0); read_count(v); check("R2 fall ignored", v, 16'h0001);
        set_pin(1'b1); set_pin(1'b0); read_count(v); check("R2 second rise", v, 16'h0002);
    endtask

    task automatic t_fall();
        logic [15:0] v;
        set_mode(2'b01);
        do_clear();
        set_pin(1'b1); read_count(v); check("R3 rise ignored", v, 16'h0000);
        set_pin(1'b0); read_count(v); check("R3 fall counted", v, 16'h0001);
    endtask

    task automatic t_pos_pulse();
        logic [15:0] v;
        set_mode(2'b10);
        do_clear();
        set_pin(1'b1); read_count(v); check("R4 opening rise alone", v, 16'h0000);
        set_pin(1'b0); read_count(v); check("R4 pulse closed", v, 16'h0001);
        set_pin(1'b1); set_pin(1'b0); set_pin(1'b1); set_pin(1'b0);
        read_count(v); check("R4 two more pulses", v, 16'h0003);
    endtask

    task automatic t_neg_pulse();
        logic [15:0] v;
        set_pin(1'b1);          // idle high before entering negative-pulse mode
        set_mode(2'b11);
        do_clear();
        set_pin(1'b0); read_count(v); check("R5 opening fall alone", v, 16'h0000);
        set_pin(1'b1); read_count(v); check("R5 pulse closed", v, 16'h0001);
        set_pin(1'b0);
    endtask

    task automatic t_mode_discard();
        logic [15:0] v;
        set_mode(2'b00);
        do_clear();
        set_pin(1'b1); read_count(v); check("R9 rise before change", v, 16'h0001);
        set_mode(2'b10);
        set_pin(1'b0); read_count(v); check("R9 partial pulse discarded", v, 16'h0001);
        set_pin(1'b1); set_pin(1'b0); read_count(v); check("R9 full pulse after change", v, 16'h0002);
    endtask

    task automatic t_clear_collide();
        logic [15:0] v;
        set_mode(2'b00);
        do_clear();
        set_pin(1'b1); set_pin(1'b0); set_pin(1'b1); set_pin(1'b0);
        read_count(v); check("R8 count before clear", v, 16'h0002);
        do_clear();
        read_count(v); check("R8 clear zeroes", v, 16'h0000);
        // the event from this rise reaches the counter on the third edge; clear lands there
        pin_async = 1'b1;
        tick(2);
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
        tick(3);
        read_count(v); check("R8 clear beats same-cycle event", v, 16'h0000);
        set_pin(1'b0);
    endtask

    task automatic t_read_hold();
        logic [15:0] v;
        set_mode(2'b00);
        do_clear();
        set_pin(1'b1); set_pin(1'b0);
        read_count(v); check("R10 read loads", v, 16'h0001);
        set_pin(1'b1); set_pin(1'b0); set_pin(1'b1); set_pin(1'b0);
        check("R10 output holds without read", count_o, 16'h0001);
        read_count(v); check("R10 new read", v, 16'h0003);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        set_mode(2'b00);
        pin_async = 1'b0;
        do_clear();
        for (int i = 0; i < 65535; i++) begin
            pin_async = 1'b1; tick(1);
            pin_async = 1'b0; tick(1);
        end
        tick(4);
        read_count(v); check("R6 back-to-back rises all counted", v, 16'hFFFF);
        set_pin(1'b1);
        read_count(v); check("R7 wrap to zero", v, 16'h0000);
        set_pin(1'b0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_rise();
        t_fall();
        t_pos_pulse();
        t_neg_pulse();
        t_mode_discard();
        t_clear_collide();
        t_read_hold();
        t_wrap();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule